// File: doc/BRIEF.md
# Masked FP32 Outer-Product Accumulator

This block applies a masked rank-1 update to a 4×4 tile of single-precision values. It takes a row vector A and a column vector B, each holding four FP32 elements. For every enabled cell (i,j) it subtracts the product A[i]·B[j] from the tile entry. The operation is written as acc + (−A[i]·B[j]), with the product negated and the accumulation positive. A 4-bit row mask and a 4-bit column mask pick the cells. A cell is enabled only when its row bit and its column bit are both set.

One multiplier and one adder are shared by all cells. A sequencer steps through the enabled cells in row-major order, one cell per clock. It does not spend cycles on cells that are masked off. The state machine has three states. ST_IDLE waits for `start`. ST_RUN processes one enabled cell per cycle. ST_DONE raises `done` for one cycle and then returns to ST_IDLE. The transitions are:
- ST_IDLE goes to ST_RUN when `start` arrives and at least one cell is enabled.
- ST_IDLE goes straight to ST_DONE when `start` arrives and no cell is enabled.
- ST_RUN goes to ST_DONE when the last pending cell is processed.

Rounding is round-to-nearest-even, applied once to the product and again to the sum. Subnormal values are flushed to signed zero. Six sticky exception flags collect the events of every operation. They stay set until `flag_clr` or reset clears them.

Top module: `outer_acc_fp32`

## Requirements
- R1: Tile cell (i,j) is stored at `tile_out` bits [32(4i+j)+31 : 32(4i+j)], and element i of each vector at bits [32i+31 : 32i]. An enabled cell becomes round(acc + (−round(A[i]·B[j]))), where each round is to nearest-even in FP32.
- R2: Cell (i,j) is updated only when `row_mask[i]` and `col_mask[j]` are both 1. Every other cell keeps the value captured from `tile_in`, so a zero mask leaves the whole tile unchanged.
- R3: Let N be the number of enabled cells (0 to 16). `done` is high for exactly one cycle, N clock edges after the edge that accepts `start`. `busy` is high in that cycle and low in the following one.
- R4: `start` is ignored while `busy` is high. `tile_out` changes only on the edge that accepts `start` or while an operation runs.
- R5: `flags` is sticky. Bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 infinity minus infinity, bit 4 infinity times zero, bit 5 signalling NaN. Only `flag_clr` or reset clears it; `flag_clr` while idle empties it on the next edge.
- R6: A product or sum too large for FP32 becomes an infinity of the correct sign and sets overflow and inexact. Adding two infinities of the same sign returns that infinity and sets no flag.
- R7: A rounded result whose biased exponent falls to 0 or below becomes a signed zero and sets underflow and inexact. Inputs with a zero exponent field are read as a signed zero and set no flag.
- R8: A signalling NaN operand sets the signalling-NaN flag. A signalling NaN has an all-ones exponent, a non-zero fraction and fraction bit 22 equal to 0. Infinity times zero and infinities of opposite sign meeting in the sum also count as invalid, each with its own flag. Every invalid case returns 0x7FC00000.
- R9: A quiet NaN operand propagates unchanged and sets no flag. A NaN accumulator takes precedence over a NaN from A, and A over B.
- R10: Exact cancellation produces +0 with no flag, even when both operands are negative.
- R11: After reset, `tile_out` and `flags` are zero and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request an update; accepted only when idle |
| row_mask | input | 4 | Row enable bits, bit i enables row i |
| col_mask | input | 4 | Column enable bits, bit j enables column j |
| vec_a | input | 128 | Row operand, four FP32 elements |
| vec_b | input | 128 | Column operand, four FP32 elements |
| tile_in | input | 512 | Accumulator tile captured on start |
| flag_clr | input | 1 | Clear the sticky flags |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| tile_out | output | 512 | Working and final accumulator tile |
| flags | output | 6 | Sticky exception flags |

## Verification
The assertions check the state-machine contract on every cycle:
- `done` is a single pulse inside `busy`, and the block is idle after it.
- The flags never lose a bit without a clear, and a clear while idle empties them.
- The tile stays frozen while idle.

Only the bench scenarios can show the arithmetic. That covers rounding, mask gating per cell, and the N-edge latency. It also covers the handling of each special operand class: overflow, flush to zero, the three invalid cases, NaN precedence and signed-zero cancellation. A random-data model is checked against the tile after every run.

// File: rtl/oacc_pkg.sv
package oacc_pkg;

    localparam int FP_W    = 32;
    localparam int SIG_W   = 27;   // hidden bit, 23 fraction bits, guard, round, sticky
    localparam int EXP_SW  = 12;   // signed working exponent
    localparam int NFLAG   = 6;

    localparam int FL_NX   = 0;
    localparam int FL_UF   = 1;
    localparam int FL_OF   = 2;
    localparam int FL_ISI  = 3;
    localparam int FL_IMZ  = 4;
    localparam int FL_SNAN = 5;

    localparam logic [FP_W-1:0] QNAN_DEFAULT = 32'h7FC0_0000;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seq_state_e;

    typedef struct packed {
        logic [NFLAG-1:0] fl;
        logic [FP_W-1:0]  val;
    } fp_res_t;

    // Round a normalised significand (leading one at bit 26) to nearest-even,
    // then range-check the rounded exponent.
    function automatic fp_res_t round_pack(input logic sgn,
                                           input logic signed [EXP_SW-1:0] e_in,
                                           input logic [SIG_W-1:0] sig);
        fp_res_t r;
        logic [24:0] m;
        logic signed [EXP_SW-1:0] e;
        logic grd, stk;
        grd = sig[2];
        stk = sig[1] | sig[0];
        m   = {1'b0, sig[26:3]} + {24'b0, grd & (stk | sig[3])};
        e   = e_in;
        if (m[24]) begin
            m = m >> 1;
            e = e + 12'sd1;
        end
        r.fl        = '0;
        r.fl[FL_NX] = grd | stk;
        if (e >= 12'sd255) begin
            r.val       = {sgn, 8'hFF, 23'b0};
            r.fl[FL_OF] = 1'b1;
            r.fl[FL_NX] = 1'b1;
        end else if (e <= 12'sd0) begin
            r.val       = {sgn, 31'b0};
            r.fl[FL_UF] = 1'b1;
            r.fl[FL_NX] = 1'b1;
        end else begin
            r.val = {sgn, e[7:0], m[22:0]};
        end
        return r;
    endfunction

endpackage

// File: rtl/oacc_mul.sv
module oacc_mul
    import oacc_pkg::*;
(
    input  logic [FP_W-1:0] a,
    input  logic [FP_W-1:0] b,
    output fp_res_t         res
);
    logic a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_zero, b_zero, sgn;
    logic [47:0] prod;
    logic [SIG_W-1:0] sig;
    logic signed [EXP_SW-1:0] e;

    always_comb begin
        a_nan  = (a[30:23] == 8'hFF) && (a[22:0] != '0);
        b_nan  = (b[30:23] == 8'hFF) && (b[22:0] != '0);
        a_snan = a_nan && !a[22];
        b_snan = b_nan && !b[22];
        a_inf  = (a[30:23] == 8'hFF) && (a[22:0] == '0);
        b_inf  = (b[30:23] == 8'hFF) && (b[22:0] == '0);
        a_zero = (a[30:23] == 8'h00);
        b_zero = (b[30:23] == 8'h00);
        sgn    = a[31] ^ b[31];

        prod = {1'b1, a[22:0]} * {1'b1, b[22:0]};
        e    = $signed({4'b0, a[30:23]}) + $signed({4'b0, b[30:23]}) - 12'sd127
             + $signed({11'b0, prod[47]});
        sig  = prod[47] ? {prod[47:22], |prod[21:0]} : {prod[46:21], |prod[20:0]};

        res = round_pack(sgn, e, sig);
        if (a_snan || b_snan) begin
            res.fl = '0;  res.fl[FL_SNAN] = 1'b1;  res.val = QNAN_DEFAULT;
        end else if (a_nan) begin
            res.fl = '0;  res.val = a;
        end else if (b_nan) begin
            res.fl = '0;  res.val = b;
        end else if ((a_inf && b_zero) || (a_zero && b_inf)) begin
            res.fl = '0;  res.fl[FL_IMZ] = 1'b1;  res.val = QNAN_DEFAULT;
        end else if (a_inf || b_inf) begin
            res.fl = '0;  res.val = {sgn, 8'hFF, 23'b0};
        end else if (a_zero || b_zero) begin
            res.fl = '0;  res.val = {sgn, 31'b0};
        end
    end
endmodule

// File: rtl/oacc_add.sv
module oacc_add
    import oacc_pkg::*;
(
    input  logic [FP_W-1:0] x,
    input  logic [FP_W-1:0] y,
    output fp_res_t         res
);
    logic x_nan, y_nan, x_snan, y_snan, x_inf, y_inf, x_zero, y_zero, swap, sub;
    logic [FP_W-1:0] bg, sm;
    logic [7:0] dexp;
    logic [SIG_W-1:0] bsig, ssig, salign, diff, nsig;
    logic [SIG_W:0] sum;
    logic signed [EXP_SW-1:0] e;
    int lead;

    always_comb begin
        x_nan  = (x[30:23] == 8'hFF) && (x[22:0] != '0);
        y_nan  = (y[30:23] == 8'hFF) && (y[22:0] != '0);
        x_snan = x_nan && !x[22];
        y_snan = y_nan && !y[22];
        x_inf  = (x[30:23] == 8'hFF) && (x[22:0] == '0);
        y_inf  = (y[30:23] == 8'hFF) && (y[22:0] == '0);
        x_zero = (x[30:23] == 8'h00);
        y_zero = (y[30:23] == 8'h00);

        swap = y[30:0] > x[30:0];
        bg   = swap ? y : x;
        sm   = swap ? x : y;
        dexp = bg[30:23] - sm[30:23];
        bsig = {1'b1, bg[22:0], 3'b0};
        ssig = {1'b1, sm[22:0], 3'b0};
        if (dexp >= 8'd27) begin
            salign = 27'd1;
        end else begin
            salign    = ssig >> dexp;
            salign[0] = salign[0] | (|(ssig & ((27'd1 << dexp) - 27'd1)));
        end
        sub  = bg[31] ^ sm[31];
        sum  = {1'b0, bsig} + {1'b0, salign};
        diff = bsig - salign;
        lead = 0;
        for (int k = 0; k < SIG_W; k++) begin
            if (diff[k]) lead = k;
        end

        e    = $signed({4'b0, bg[30:23]});
        nsig = sum[SIG_W-1:0];
        if (sub) begin
            nsig = diff << (26 - lead);
            e    = e - 12'(26 - lead);
        end else if (sum[SIG_W]) begin
            nsig = {sum[27:2], |sum[1:0]};
            e    = e + 12'sd1;
        end

        res = round_pack(bg[31], e, nsig);
        if (x_snan || y_snan) begin
            res.fl = '0;  res.fl[FL_SNAN] = 1'b1;  res.val = QNAN_DEFAULT;
        end else if (x_nan) begin
            res.fl = '0;  res.val = x;
        end else if (y_nan) begin
            res.fl = '0;  res.val = y;
        end else if (x_inf && y_inf && (x[31] != y[31])) begin
            res.fl = '0;  res.fl[FL_ISI] = 1'b1;  res.val = QNAN_DEFAULT;
        end else if (x_inf) begin
            res.fl = '0;  res.val = x;
        end else if (y_inf) begin
            res.fl = '0;  res.val = y;
        end else if (x_zero && y_zero) begin
            res.fl = '0;  res.val = {x[31] & y[31], 31'b0};
        end else if (x_zero) begin
            res.fl = '0;  res.val = y;
        end else if (y_zero) begin
            res.fl = '0;  res.val = x;
        end else if (sub && (diff == '0)) begin
            res.fl = '0;  res.val = '0;
        end
    end
endmodule

// File: rtl/outer_acc_fp32.sv
module outer_acc_fp32
    import oacc_pkg::*;
#(
    parameter int DIM = 4
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [DIM-1:0]          row_mask,
    input  logic [DIM-1:0]          col_mask,
    input  logic [DIM*FP_W-1:0]     vec_a,
    input  logic [DIM*FP_W-1:0]     vec_b,
    input  logic [DIM*DIM*FP_W-1:0] tile_in,
    input  logic                    flag_clr,
    output logic                    busy,
    output logic                    done,
    output logic [DIM*DIM*FP_W-1:0] tile_out,
    output logic [NFLAG-1:0]        flags
);
    localparam int CELLS  = DIM * DIM;
    localparam int IDX_W  = $clog2(CELLS);
    localparam int VEC_W  = DIM * FP_W;
    localparam int TILE_W = CELLS * FP_W;

    seq_state_e state_q, state_d;
    logic [VEC_W-1:0]  a_q, b_q;
    logic [TILE_W-1:0] tile_q;
    logic [CELLS-1:0]  pend_q, grid_en, pick_oh, pend_rest;
    logic [NFLAG-1:0]  flags_q;
    logic [IDX_W-1:0]  pick_idx;
    logic              found;
    logic [FP_W-1:0]   a_el, b_el, acc_el, neg_prod;
    fp_res_t           prod_r, sum_r;

    // Enable grid: outer product of the two masks.
    for (genvar gi = 0; gi < DIM; gi++) begin : g_row
        for (genvar gj = 0; gj < DIM; gj++) begin : g_col
            assign grid_en[gi*DIM+gj] = row_mask[gi] & col_mask[gj];
        end
    end

    // Lowest pending cell is the next one in row-major order.
    always_comb begin
        pick_idx = '0;
        found    = 1'b0;
        for (int k = 0; k < CELLS; k++) begin
            if (pend_q[k] && !found) begin
                pick_idx = IDX_W'(k);
                found    = 1'b1;
            end
        end
        pick_oh   = CELLS'(1) << pick_idx;
        pend_rest = pend_q & ~pick_oh;
        a_el      = a_q[(int'(pick_idx) / DIM) * FP_W +: FP_W];
        b_el      = b_q[(int'(pick_idx) % DIM) * FP_W +: FP_W];
        acc_el    = tile_q[int'(pick_idx) * FP_W +: FP_W];
    end

    oacc_mul u_mul (.a(a_el), .b(b_el), .res(prod_r));

    // Negate the product; a NaN passes through untouched.
    assign neg_prod = ((prod_r.val[30:23] == 8'hFF) && (prod_r.val[22:0] != '0))
                    ? prod_r.val : {~prod_r.val[31], prod_r.val[30:0]};

    oacc_add u_add (.x(acc_el), .y(neg_prod), .res(sum_r));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (|grid_en) ? ST_RUN : ST_DONE;
            ST_RUN:  if (pend_rest == '0) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Operand, tile and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            tile_q  <= '0;
            pend_q  <= '0;
            flags_q <= '0;
        end else begin
            flags_q <= (flag_clr ? '0 : flags_q)
                     | ((state_q == ST_RUN) ? (prod_r.fl | sum_r.fl) : '0);
            unique case (state_q)
                ST_IDLE: if (start) begin
                    a_q    <= vec_a;
                    b_q    <= vec_b;
                    tile_q <= tile_in;
                    pend_q <= grid_en;
                end
                ST_RUN: begin
                    tile_q[int'(pick_idx) * FP_W +: FP_W] <= sum_r.val;
                    pend_q <= pend_rest;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_DONE);
        tile_out = tile_q;
        flags    = flags_q;
    end
endmodule

// File: rtl/oacc_chk.sv
module oacc_chk #(
    parameter int TILE_W = 512,
    parameter int NF     = 6
)(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              flag_clr,
    input logic              busy,
    input logic              done,
    input logic [NF-1:0]     flags,
    input logic [TILE_W-1:0] tile_out
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R3
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R3
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr |=> ((flags & $past(flags)) == $past(flags))); // R5
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !busy) |=> (flags == '0)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(tile_out)); // R4
endmodule

bind outer_acc_fp32 oacc_chk #(.TILE_W(512), .NF(6)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .flag_clr(flag_clr),
    .busy(busy), .done(done), .flags(flags), .tile_out(tile_out)
);

// File: tb/outer_acc_fp32_test.sv
`timescale 1ns/1ps
module outer_acc_fp32_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n, start, flag_clr, busy, done;
    logic [3:0]   row_mask, col_mask;
    logic [127:0] vec_a, vec_b;
    logic [511:0] tile_in, tile_out;
    logic [5:0]   flags;

    outer_acc_fp32 uut (
        .clk(clk), .rst_n(rst_n), .start(start), .row_mask(row_mask), .col_mask(col_mask),
        .vec_a(vec_a), .vec_b(vec_b), .tile_in(tile_in), .flag_clr(flag_clr),
        .busy(busy), .done(done), .tile_out(tile_out), .flags(flags)
    );

    int n_vec = 0, n_bad = 0;
    logic [31:0] ta[4], tb[4], tacc[16], texp[16];
    logic [5:0]  eflags;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, expv);
        end
    endtask

    function automatic real f2r(input logic [31:0] v);
        if (v[30:23] == 8'h00) return $bitstoreal({v[31], 63'b0});
        return $bitstoreal({v[31], 11'({3'b0, v[30:23]} + 11'd896), v[22:0], 29'b0});
    endfunction

    // Round a double to FP32 nearest-even, flushing out-of-range results.
    function automatic logic [37:0] r2f(input real x);
        logic [63:0] d;
        logic [24:0] m;
        logic g, rest;
        int be;
        logic [5:0] fl;
        d  = $realtobits(x);
        fl = '0;
        if (d[62:52] == 11'd0) return {6'b0, d[63], 31'b0};
        be   = int'(d[62:52]) - 896;
        g    = d[28];
        rest = |d[27:0];
        m    = {2'b01, d[51:29]} + 25'(g & (rest | d[29]));
        if (m[24]) begin m = m >> 1; be++; end
        fl[0] = g | rest;
        if (be >= 255) return {fl | 6'b000101, d[63], 8'hFF, 23'b0};
        if (be <= 0)   return {fl | 6'b000011, d[63], 31'b0};
        return {fl, d[63], 8'(be), m[22:0]};
    endfunction

    function automatic logic [37:0] ref_cell(input logic [31:0] a, b, acc);
        logic [37:0] p, s;
        p = r2f(f2r(a) * f2r(b));
        s = r2f(f2r(acc) + f2r({~p[31], p[30:0]}));
        return {p[37:32] | s[37:32], s[31:0]};
    endfunction

    function automatic logic [31:0] rnd_norm();
        return {1'($urandom), 8'(100 + ($urandom % 55)), 23'($urandom)};
    endfunction

    task automatic fill_random();
        for (int i = 0; i < 4; i++) begin ta[i] = rnd_norm(); tb[i] = rnd_norm(); end
        for (int k = 0; k < 16; k++) tacc[k] = rnd_norm();
    endtask

    task automatic expect_ref(input logic [3:0] rm, input logic [3:0] cm);
        logic [37:0] r;
        for (int k = 0; k < 16; k++) begin
            texp[k] = tacc[k];
            if (rm[k/4] && cm[k%4]) begin
                r       = ref_cell(ta[k/4], tb[k%4], tacc[k]);
                texp[k] = r[31:0];
                eflags  = eflags | r[37:32];
            end
        end
    endtask

    task automatic run_op(input logic [3:0] rm, input logic [3:0] cm, input bit poke, input string tag);
        int n, k;
        n = 0;
        for (int c = 0; c < 16; c++) if (rm[c/4] && cm[c%4]) n++;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            vec_a[32*i +: 32] = ta[i];
            vec_b[32*i +: 32] = tb[i];
        end
        for (int c = 0; c < 16; c++) tile_in[32*c +: 32] = tacc[c];
        row_mask = rm; col_mask = cm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 40) begin
            if (poke && k == 1) begin
                // R4: a second request while running must be dropped
                start = 1'b1; row_mask = 4'hF; col_mask = 4'hF;
                tile_in = ~tile_in; vec_a = ~vec_a;
            end
            @(negedge clk);
            start = 1'b0;
            k++;
        end
        chk(k == n, "R3 latency", 32'(k), 32'(n));
        chk(busy == 1'b1, "R3 busy with done", 32'(busy), 32'd1);
        for (int c = 0; c < 16; c++)
            chk(tile_out[32*c +: 32] === texp[c], (rm[c/4] && cm[c%4]) ? tag : "R2 masked cell",
                tile_out[32*c +: 32], texp[c]);
        chk(flags === eflags, "R5 flags", 32'(flags), 32'(eflags));
        @(negedge clk);
        chk(!done && !busy, "R3 single pulse", {30'b0, done, busy}, 32'd0);
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk(flags == 6'd0, "R5 clear", 32'(flags), 32'd0);
        eflags = '0;
    endtask

    // One special case placed in cell (1,2), index 6, with all other cells masked off.
    task automatic directed(input logic [31:0] a, b, acc, res, input logic [5:0] fl, input string tag);
        fill_random();
        ta[1] = a; tb[2] = b; tacc[6] = acc;
        clear_flags();
        for (int c = 0; c < 16; c++) texp[c] = tacc[c];
        texp[6] = res;
        eflags  = fl;
        run_op(4'b0010, 4'b0100, 1'b0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        bit poke;
        logic [3:0] rm, cm;
        void'($urandom(32'd715));
        rst_n = 1'b0; start = 1'b0; flag_clr = 1'b0;
        row_mask = '0; col_mask = '0; vec_a = '0; vec_b = '0; tile_in = '0;
        eflags = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tile_out == '0, "R11 tile", tile_out[31:0], 32'd0);
        chk(flags == '0, "R11 flags", 32'(flags), 32'd0);
        chk(!busy && !done, "R11 idle", {30'b0, busy, done}, 32'd0);

        fill_random(); expect_ref(4'hF, 4'hF); run_op(4'hF, 4'hF, 1'b0, "R1 full tile");
        fill_random(); expect_ref(4'h0, 4'hF); run_op(4'h0, 4'hF, 1'b0, "R2 empty mask");
        fill_random(); expect_ref(4'h9, 4'h0); run_op(4'h9, 4'h0, 1'b0, "R2 empty mask");

        for (int t = 0; t < 30; t++) begin
            fill_random();
            rm = 4'($urandom); cm = 4'($urandom); poke = 1'($urandom);
            expect_ref(rm, cm);
            run_op(rm, cm, poke, poke ? "R4 start ignored" : "R1 random");
        end
        clear_flags();

        directed(32'h7E800000, 32'h7E800000, 32'h3F800000, 32'hFF800000, 6'd5, "R6 product overflow");
        directed(32'h7F7FFFFF, 32'hBF800000, 32'h7F7FFFFF, 32'h7F800000, 6'd5, "R6 sum overflow");
        directed(32'h3F800000, 32'hFF800000, 32'h7F800000, 32'h7F800000, 6'd0, "R6 like infinities");
        directed(32'h0A000000, 32'h0A000000, 32'h3F800000, 32'h3F800000, 6'd3, "R7 product underflow");
        directed(32'h3F800000, 32'h00800000, 32'h00C00000, 32'h00000000, 6'd3, "R7 sum underflow");
        directed(32'h00000001, 32'h3F800000, 32'h40000000, 32'h40000000, 6'd0, "R7 subnormal input");
        directed(32'h7F800001, 32'h3F800000, 32'h3F800000, 32'h7FC00000, 6'd32, "R8 snan operand");
        directed(32'h3F800000, 32'h3F800000, 32'hFF800010, 32'h7FC00000, 6'd32, "R8 snan accumulator");
        directed(32'hFF800000, 32'h00000000, 32'h3F800000, 32'h7FC00000, 6'd16, "R8 inf times zero");
        directed(32'h3F800000, 32'h7F800000, 32'h7F800000, 32'h7FC00000, 6'd8, "R8 inf minus inf");
        directed(32'h7FC00ABC, 32'h3F800000, 32'h7FC12345, 32'h7FC12345, 6'd0, "R9 acc nan first");
        directed(32'h7FC00ABC, 32'hFFC00777, 32'h3F800000, 32'h7FC00ABC, 6'd0, "R9 A before B");
        directed(32'h3F800000, 32'hFFC00777, 32'h3F800000, 32'hFFC00777, 6'd0, "R9 B nan");
        directed(32'h40000000, 32'h40400000, 32'h40C00000, 32'h00000000, 6'd0, "R10 cancel");
        directed(32'hC0000000, 32'h40400000, 32'hC0C00000, 32'h00000000, 6'd0, "R10 negative cancel");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule